// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches a stream of demand loads. Each load carries the address of the instruction that issued it and the byte address it touched. A small, fully associative table is keyed by the instruction address. For each tracked instruction the table remembers the last data address, the last byte distance between two of its accesses, and a saturating confidence count.

When an instruction repeats the same non-zero byte distance, the block offers the next expected address on a valid/ready prefetch port. That address is the current access address plus the distance. The distance may be positive or negative. It must not exceed a maximum magnitude in either direction, and the target must fall in a different cache line from the access that produced it.

The block only produces addresses. The cache, miss handling, memory traffic and translation sit elsewhere. A single output register holds an offered request while the consumer stalls, and any newer candidates are discarded during that time.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset `pfValid` is 0, and the first load of an instruction address that is not yet tracked never produces a prefetch.
- R2: History is kept separately for each instruction address. Loads from two instructions that interleave train independently, and each one issues its own target.
- R3: A prefetch needs two consecutive equal non-zero strides from the same instruction. The first and second accesses give nothing. On the third, `pfValid` rises on the clock edge that takes in the load, with `pfAddr` equal to the load address plus the stride.
- R4: Negative strides are tracked. The target is the load address minus the stride magnitude, with wrap in `ADDR_W` bits.
- R5: A stride whose magnitude is larger than `MAX_STRIDE` (2048 bytes) issues no prefetch. A stride of exactly 2048 bytes does issue one.
- R6: A zero stride, meaning the same address repeated by one instruction, never issues a prefetch.
- R7: A stride that differs from the stored stride clears confidence and replaces the stored stride. That access issues nothing. The next access that repeats the new stride does issue.
- R8: A target whose bits above the 64-byte line offset (`ldAddr[ADDR_W-1:6]`) equal those of the current access is suppressed.
- R9: The table holds `ENTRIES` (16) instruction addresses with least-recently-used replacement. A trained instruction survives 15 newer distinct instructions. The 16th newer one evicts it, so its next access issues nothing.
- R10: While `pfValid` is 1 and `pfReady` is 0, `pfValid` and `pfAddr` stay unchanged, and newer candidates are dropped.
- R11: A request is taken when `pfValid` and `pfReady` are both 1. If no new candidate arrives on that edge, `pfValid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | A demand load is present this cycle |
| ldPc | input | PC_W | Address of the issuing load instruction |
| ldAddr | input | ADDR_W | Byte address accessed by the load |
| pfValid | output | 1 | Prefetch request is offered |
| pfReady | input | 1 | Consumer accepts the offered request |
| pfAddr | output | ADDR_W | Prefetch byte address |

## Verification
The bench builds the block with its default values: 32-bit instruction and data addresses, 16 table entries, a 2048-byte stride limit, 64-byte lines and an issue threshold of one confidence step. These values place the exact stride limit within reach using small address offsets. Line-crossing suppression can be shown with an 8-byte stride. Eviction needs only seventeen distinct instruction addresses, so the boundary between surviving 15 newer instructions and being displaced by the 16th is checked directly.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  localparam int CONF_W = 2;

  // Observations from the datapath about the current load.
  typedef struct packed {
    logic hit;
    logic strideSame;
    logic strideNonZero;
    logic strideInRange;
    logic sameLine;
    logic confReady;
  } obs_t;

  // Strobes from control into the datapath.
  typedef struct packed {
    logic alloc;
    logic train;
    logic confInc;
    logic loadOut;
  } ctrl_t;
endpackage

// File: rtl/stride_pf_datapath.sv
module stride_pf_datapath
  import stride_pf_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int MAX_STRIDE = 2048,
  parameter int LINE_BYTES = 64,
  parameter int ISSUE_CONF = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  input  ctrl_t             ctrl,
  output obs_t              obs,
  output logic [ADDR_W-1:0] pfAddr
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
  localparam logic signed [ADDR_W-1:0] STRIDE_LIM = ADDR_W'(MAX_STRIDE);

  logic                     validQ    [ENTRIES];
  logic [PC_W-1:0]          tagQ      [ENTRIES];
  logic [ADDR_W-1:0]        lastAddrQ [ENTRIES];
  logic signed [ADDR_W-1:0] strideQ   [ENTRIES];
  logic [CONF_W-1:0]        confQ     [ENTRIES];
  logic [IDX_W-1:0]         ageQ      [ENTRIES];

  logic [ENTRIES-1:0] hitVec, victimVec;
  logic [IDX_W-1:0]   hitIdx, victimIdx, selIdx;
  logic               anyHit;
  logic signed [ADDR_W-1:0] newStride;
  logic [ADDR_W-1:0]  target;
  logic [CONF_W-1:0]  confBumped;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hitVec[i]    = validQ[i] && (tagQ[i] == ldPc);
    assign victimVec[i] = (ageQ[i] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i])    hitIdx    = IDX_W'(i);
      if (victimVec[i]) victimIdx = IDX_W'(i);
    end
  end

  assign anyHit     = |hitVec;
  assign selIdx     = anyHit ? hitIdx : victimIdx;
  assign newStride  = ldAddr - lastAddrQ[hitIdx];
  assign target     = ldAddr + newStride;
  assign confBumped = (confQ[hitIdx] == CONF_MAX) ? CONF_MAX : confQ[hitIdx] + 1'b1;

  always_comb begin
    obs.hit           = anyHit;
    obs.strideSame    = (newStride == strideQ[hitIdx]);
    obs.strideNonZero = (newStride != '0);
    obs.strideInRange = (newStride <= STRIDE_LIM) && (newStride >= -STRIDE_LIM);
    obs.sameLine      = (target[ADDR_W-1:LINE_SH] == ldAddr[ADDR_W-1:LINE_SH]);
    obs.confReady     = (confBumped >= CONF_W'(ISSUE_CONF));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i]    <= 1'b0;
        tagQ[i]      <= '0;
        lastAddrQ[i] <= '0;
        strideQ[i]   <= '0;
        confQ[i]     <= '0;
        ageQ[i]      <= IDX_W'(i);
      end
      pfAddr <= '0;
    end else begin
      if (ctrl.alloc) begin
        validQ[selIdx]    <= 1'b1;
        tagQ[selIdx]      <= ldPc;
        lastAddrQ[selIdx] <= ldAddr;
        strideQ[selIdx]   <= '0;
        confQ[selIdx]     <= '0;
      end else if (ctrl.train) begin
        lastAddrQ[selIdx] <= ldAddr;
        strideQ[selIdx]   <= newStride;
        confQ[selIdx]     <= ctrl.confInc ? confBumped : '0;
      end
      if (ctrl.alloc || ctrl.train) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (IDX_W'(j) == selIdx)        ageQ[j] <= '0;
          else if (ageQ[j] < ageQ[selIdx]) ageQ[j] <= ageQ[j] + 1'b1;
        end
      end
      if (ctrl.loadOut) pfAddr <= target;
    end
  end

  p_victim_unique_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(victimVec) == 1);

  p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_other_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadOut |=> pfAddr[ADDR_W-1:LINE_SH] != $past(ldAddr[ADDR_W-1:LINE_SH]));
endmodule

// File: rtl/stride_pf_control.sv
module stride_pf_control
  import stride_pf_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  ldValid,
  input  logic  pfReady,
  input  obs_t  obs,
  output ctrl_t ctrl,
  output logic  pfValid
);
  logic issueCand;

  always_comb begin
    issueCand = ldValid && obs.hit && obs.strideSame && obs.strideNonZero &&
                obs.strideInRange && !obs.sameLine && obs.confReady;
    ctrl.alloc   = ldValid && !obs.hit;
    ctrl.train   = ldValid && obs.hit;
    ctrl.confInc = obs.strideSame && obs.strideNonZero;
    ctrl.loadOut = issueCand && (!pfValid || pfReady);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pfValid <= 1'b0;
    else if (ctrl.loadOut) pfValid <= 1'b1;
    else if (pfReady)      pfValid <= 1'b0;
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> pfValid);

  p_accept_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && pfReady && !ctrl.loadOut) |=> !pfValid);

  p_zero_never_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !obs.strideNonZero && !pfValid) |=> !pfValid);

  p_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && obs.hit && !obs.strideInRange && !pfValid) |=> !pfValid);
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import stride_pf_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int MAX_STRIDE = 2048,
  parameter int LINE_BYTES = 64,
  parameter int ISSUE_CONF = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr
);
  obs_t  obs;
  ctrl_t ctrl;

  stride_pf_datapath #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES),
    .MAX_STRIDE(MAX_STRIDE), .LINE_BYTES(LINE_BYTES), .ISSUE_CONF(ISSUE_CONF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ldPc(ldPc), .ldAddr(ldAddr),
    .ctrl(ctrl), .obs(obs), .pfAddr(pfAddr)
  );

  stride_pf_control u_ctl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .pfReady(pfReady),
    .obs(obs), .ctrl(ctrl), .pfValid(pfValid)
  );

  p_stall_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> $stable(pfAddr));
endmodule

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ldValid;
  logic [31:0] ldPc;
  logic [31:0] ldAddr;
  logic        pfValid;
  logic        pfReady;
  logic [31:0] pfAddr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stride_prefetcher u_stride_prefetcher (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldPc(ldPc), .ldAddr(ldAddr),
    .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr)
  );

  task automatic expectPf(string req, logic expV, logic [31:0] expA);
    checks++;
    if (pfValid !== expV || (expV && pfAddr !== expA)) begin
      errors++;
      $display("FAIL %s: pfValid=%0b pfAddr=%h expected pfValid=%0b pfAddr=%h",
               req, pfValid, pfAddr, expV, expA);
    end
  endtask

  task automatic doLoad(logic [31:0] pc, logic [31:0] addr);
    @(negedge clk);
    ldValid = 1'b1; ldPc = pc; ldAddr = addr;
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic testReset();
    expectPf("R1 reset", 1'b0, '0);
    doLoad(32'h1000, 32'h0009_0000);
    expectPf("R1 first load", 1'b0, '0);
  endtask

  task automatic testBasic();
    doLoad(32'h1100, 32'h0001_0000);
    expectPf("R3 first access", 1'b0, '0);
    doLoad(32'h1100, 32'h0001_0100);
    expectPf("R3 second access", 1'b0, '0);
    doLoad(32'h1100, 32'h0001_0200);
    expectPf("R3 third access", 1'b1, 32'h0001_0300);
    @(negedge clk);
    expectPf("R11 accepted then clear", 1'b0, '0);
  endtask

  task automatic testInterleave();
    doLoad(32'h1200, 32'h0004_0000);
    doLoad(32'h1204, 32'h0005_0000);
    doLoad(32'h1200, 32'h0004_0100);
    doLoad(32'h1204, 32'h0004_FE00);
    doLoad(32'h1200, 32'h0004_0200);
    expectPf("R2 pc A", 1'b1, 32'h0004_0300);
    doLoad(32'h1204, 32'h0004_FC00);
    expectPf("R2 pc B", 1'b1, 32'h0004_FA00);
  endtask

  task automatic testNegative();
    doLoad(32'h1300, 32'h0000_8000);
    doLoad(32'h1300, 32'h0000_7F80);
    doLoad(32'h1300, 32'h0000_7F00);
    expectPf("R4 negative stride", 1'b1, 32'h0000_7E80);
  endtask

  task automatic testRange();
    doLoad(32'h1400, 32'h0010_0000);
    doLoad(32'h1400, 32'h0010_0800);
    doLoad(32'h1400, 32'h0010_1000);
    expectPf("R5 stride 2048", 1'b1, 32'h0010_1800);
    doLoad(32'h1404, 32'h0020_0000);
    doLoad(32'h1404, 32'h0020_0840);
    doLoad(32'h1404, 32'h0020_1080);
    expectPf("R5 stride 2112", 1'b0, '0);
    doLoad(32'h1408, 32'h0030_0000);
    doLoad(32'h1408, 32'h002F_F7C0);
    doLoad(32'h1408, 32'h002F_EF80);
    expectPf("R5 stride -2112", 1'b0, '0);
  endtask

  task automatic testZero();
    doLoad(32'h1500, 32'h0006_0000);
    doLoad(32'h1500, 32'h0006_0000);
    doLoad(32'h1500, 32'h0006_0000);
    expectPf("R6 zero stride", 1'b0, '0);
  endtask

  task automatic testChange();
    doLoad(32'h1600, 32'h0000_3000);
    doLoad(32'h1600, 32'h0000_3100);
    doLoad(32'h1600, 32'h0000_3200);
    expectPf("R7 trained", 1'b1, 32'h0000_3300);
    doLoad(32'h1600, 32'h0000_3240);
    expectPf("R7 mismatch", 1'b0, '0);
    doLoad(32'h1600, 32'h0000_3280);
    expectPf("R7 new stride", 1'b1, 32'h0000_32C0);
  endtask

  task automatic testSameLine();
    doLoad(32'h1700, 32'h0000_2000);
    doLoad(32'h1700, 32'h0000_2008);
    doLoad(32'h1700, 32'h0000_2010);
    expectPf("R8 same line", 1'b0, '0);
    doLoad(32'h1700, 32'h0000_2038);
    doLoad(32'h1700, 32'h0000_2060);
    expectPf("R8 crosses line", 1'b1, 32'h0000_2088);
  endtask

  task automatic testLru();
    doLoad(32'h1800, 32'h0007_0000);
    doLoad(32'h1800, 32'h0007_0100);
    for (int k = 0; k < 15; k++) doLoad(32'h2000 + 32'(k * 4), 32'h0008_0000);
    doLoad(32'h1800, 32'h0007_0200);
    expectPf("R9 survives 15", 1'b1, 32'h0007_0300);
    for (int k = 0; k < 16; k++) doLoad(32'h3000 + 32'(k * 4), 32'h0008_0000);
    doLoad(32'h1800, 32'h0007_0300);
    expectPf("R9 evicted by 16th", 1'b0, '0);
  endtask

  task automatic testStall();
    pfReady = 1'b0;
    doLoad(32'h1900, 32'h000A_0000);
    doLoad(32'h1900, 32'h000A_0100);
    doLoad(32'h1900, 32'h000A_0200);
    expectPf("R10 offered", 1'b1, 32'h000A_0300);
    doLoad(32'h1900, 32'h000A_0300);
    expectPf("R10 newer dropped", 1'b1, 32'h000A_0300);
    @(negedge clk);
    expectPf("R10 held", 1'b1, 32'h000A_0300);
    pfReady = 1'b1;
    @(negedge clk);
    expectPf("R11 after accept", 1'b0, '0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; ldValid = 1'b0; ldPc = '0; ldAddr = '0; pfReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testInterleave();
    testNegative();
    testRange();
    testZero();
    testChange();
    testSameLine();
    testLru();
    testStall();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule